// File: doc/BRIEF.md
# Core-to-Slow-Clock Configuration Register Bank

This block holds a small bank of configuration registers that software writes on a fast core clock, while the logic that uses them runs on a slow, low-frequency clock. Each register has three parts: a holding copy on the core side, its own clock-crossing channel, and a shadow copy on the slow side that drives the peripheral. A core write lands in the holding copy at once and raises that register's busy bit. The channel then moves the value across. The busy bit drops only after the slow-side shadow has taken the value and that completion has travelled back to the core side.

A freeze input stops all shadow updates while it is high. Several writes can then be staged and released together. One extra register holds a value that the peripheral maintains itself. The slow side publishes it to the core side through a toggle handshake, and the core side reads that captured copy. The read port is combinational on the core clock. Addresses 0 to N-1 return the holding copies. Address N returns the busy status. Address N+1 returns the published peripheral value. All higher addresses return zero.

Each channel has two small state machines. The core machine has the states C_IDLE and C_BUSY. It moves C_IDLE→C_BUSY on an accepted write. It moves C_BUSY→C_IDLE when the returned acknowledge toggle equals the request toggle. The slow machine has the states L_IDLE and L_HOLD. It moves L_IDLE→L_HOLD when a new request arrives while freeze is active. It moves L_HOLD→L_IDLE when freeze is released, and the shadow loads on that move. When a request arrives with no freeze, the shadow loads and the machine stays in L_IDLE. The publisher machine has the states P_CAPT and P_WAIT. It moves P_CAPT→P_WAIT after it samples the peripheral value and flips its toggle. It moves P_WAIT→P_CAPT once the core-side acknowledge matches.

Top module: `lfreg_sync_bank`

## Requirements
- R1: While reset is low and after it is released, the status register reads 0, every holding copy and the published value read 0, and every slow-side shadow is 0.
- R2: A write to register i while bit i of the status word (address N) is 0 sets bit i. The new bit is visible right after the core clock edge that takes the write.
- R3: Reading address i right after an accepted write returns the new value, while busy bit i is still 1.
- R4: The slow-side shadow of register i takes the new value on the third rising slow-clock edge after the write edge. After the second of those edges it still holds the old value.
- R5: Busy bit i is still 1 just after that third slow edge. It reads 0 no more than four core clock edges later.
- R6: A write to register i while busy bit i is 1 is ignored. The holding copy keeps the first value, and the shadow ends with the first value.
- R7: Registers are independent. Writes to two registers on back-to-back core cycles set both their status bits, and each shadow receives its own value.
- R8: While freeze is high, no shadow changes and busy bits of pending writes stay 1. After release, every pending shadow updates and all busy bits clear.
- R9: Address N+1 returns the value on the slow-side peripheral input once it has been stable for twelve slow-clock cycles, and it follows later changes.
- R10: Addresses above N+1 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Fast core clock |
| clk_lf | input | 1 | Slow low-frequency clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, core domain |
| wr_idx | input | IW | Index of the register being written |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address (0..N-1 copies, N status, N+1 peripheral value) |
| rd_data | output | DW | Combinational read data |
| freeze | input | 1 | Holds all slow-side shadows while high (core domain) |
| lf_stat_in | input | DW | Peripheral-maintained value, slow domain |
| lf_regs | output | N*DW | Slow-side shadows, register i in bits i*DW +: DW |

## Verification
Readback and the busy bit are due right after the core edge that takes a write, so the bench samples them one nanosecond after its write task returns. The slow clock is offset from the core clock, so no slow edge falls between the write edge and the next core falling edge. The bench counts slow rising edges from that point: it samples the shadow one nanosecond after the second edge, expecting the old value, and after the third, expecting the new one. Busy clearing is due within three core edges of the third slow edge, and the bench checks it after four. Freeze and the published value each cross two synchronizer stages plus a handshake, so the bench waits fixed, larger numbers of slow edges before it samples them.

// File: rtl/lfreg_sync_pkg.sv
package lfreg_sync_pkg;
    typedef enum logic {C_IDLE, C_BUSY} core_st_t;
    typedef enum logic {L_IDLE, L_HOLD} lf_st_t;
    typedef enum logic {P_CAPT, P_WAIT} pub_st_t;
endpackage

// File: rtl/lfreg_bit_sync.sv
module lfreg_bit_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lfreg_wr_chan.sv
module lfreg_wr_chan
    import lfreg_sync_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk_core,
    input  logic          clk_lf,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    input  logic          freeze_lf,
    output logic [DW-1:0] core_q,
    output logic          busy,
    output logic [DW-1:0] lf_q
);
    // ---------------- core side ----------------
    core_st_t c_st, c_nx;
    logic     req_t;
    logic     ack_c;
    logic     lf_ack;
    logic     accept;

    assign accept = wr_hit && (c_st == C_IDLE);

    always_ff @(posedge clk_core or negedge rst_n) begin
        if (!rst_n) c_st <= C_IDLE;
        else        c_st <= c_nx;
    end

    always_comb begin
        c_nx = c_st;
        unique case (c_st)
            C_IDLE: if (wr_hit)          c_nx = C_BUSY;
            C_BUSY: if (ack_c == req_t)  c_nx = C_IDLE;
        endcase
    end

    always_ff @(posedge clk_core or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
            req_t  <= 1'b0;
        end else if (accept) begin
            core_q <= wr_data;
            req_t  <= ~req_t;
        end
    end

    always_comb busy = (c_st == C_BUSY);

    lfreg_bit_sync u_ack_sync (
        .clk   (clk_core),
        .rst_n (rst_n),
        .d     (lf_ack),
        .q     (ack_c)
    );

    // ---------------- slow side ----------------
    lf_st_t l_st, l_nx;
    logic   req_l;
    logic   pending;
    logic   take;

    lfreg_bit_sync u_req_sync (
        .clk   (clk_lf),
        .rst_n (rst_n),
        .d     (req_t),
        .q     (req_l)
    );

    assign pending = (req_l != lf_ack);

    always_ff @(posedge clk_lf or negedge rst_n) begin
        if (!rst_n) l_st <= L_IDLE;
        else        l_st <= l_nx;
    end

    always_comb begin
        l_nx = l_st;
        unique case (l_st)
            L_IDLE: if (pending && freeze_lf) l_nx = L_HOLD;
            L_HOLD: if (!freeze_lf)           l_nx = L_IDLE;
        endcase
    end

    always_comb begin
        unique case (l_st)
            L_IDLE: take = pending && !freeze_lf;
            L_HOLD: take = !freeze_lf;
        endcase
    end

    always_ff @(posedge clk_lf or negedge rst_n) begin
        if (!rst_n) begin
            lf_q   <= '0;
            lf_ack <= 1'b0;
        end else if (take) begin
            lf_q   <= core_q;
            lf_ack <= ~lf_ack;
        end
    end
endmodule

// File: rtl/lfreg_pub_xfer.sv
module lfreg_pub_xfer
    import lfreg_sync_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk_core,
    input  logic          clk_lf,
    input  logic          rst_n,
    input  logic [DW-1:0] lf_val,
    output logic [DW-1:0] core_val
);
    pub_st_t p_st, p_nx;
    logic [DW-1:0] hold;
    logic          p_tgl;
    logic          ack_l;
    logic          tgl_c;
    logic          tgl_d;

    // slow side publisher
    always_ff @(posedge clk_lf or negedge rst_n) begin
        if (!rst_n) p_st <= P_CAPT;
        else        p_st <= p_nx;
    end

    always_comb begin
        p_nx = p_st;
        unique case (p_st)
            P_CAPT: p_nx = P_WAIT;
            P_WAIT: if (ack_l == p_tgl) p_nx = P_CAPT;
        endcase
    end

    always_ff @(posedge clk_lf or negedge rst_n) begin
        if (!rst_n) begin
            hold  <= '0;
            p_tgl <= 1'b0;
        end else if (p_st == P_CAPT) begin
            hold  <= lf_val;
            p_tgl <= ~p_tgl;
        end
    end

    lfreg_bit_sync u_ack_sync (
        .clk   (clk_lf),
        .rst_n (rst_n),
        .d     (tgl_d),
        .q     (ack_l)
    );

    // core side capture
    lfreg_bit_sync u_tgl_sync (
        .clk   (clk_core),
        .rst_n (rst_n),
        .d     (p_tgl),
        .q     (tgl_c)
    );

    always_ff @(posedge clk_core or negedge rst_n) begin
        if (!rst_n) begin
            core_val <= '0;
            tgl_d    <= 1'b0;
        end else if (tgl_c != tgl_d) begin
            core_val <= hold;
            tgl_d    <= tgl_c;
        end
    end
endmodule

// File: rtl/lfreg_sync_bank.sv
module lfreg_sync_bank #(
    parameter int N  = 4,
    parameter int DW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int AW = $clog2(N + 2)
) (
    input  logic            clk_core,
    input  logic            clk_lf,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            freeze,
    input  logic [DW-1:0]   lf_stat_in,
    output logic [N*DW-1:0] lf_regs
);
    logic [DW-1:0]   core_q [N];
    logic [N*DW-1:0] core_flat;
    logic [N-1:0]    busy_vec;
    logic [DW-1:0]   pub_val;
    logic            freeze_lf;

    lfreg_bit_sync u_frz_sync (
        .clk   (clk_lf),
        .rst_n (rst_n),
        .d     (freeze),
        .q     (freeze_lf)
    );

    for (genvar i = 0; i < N; i++) begin : g_chan
        logic hit;
        assign hit = wr_en && (wr_idx == IW'(i));

        lfreg_wr_chan #(.DW(DW)) u_chan (
            .clk_core  (clk_core),
            .clk_lf    (clk_lf),
            .rst_n     (rst_n),
            .wr_hit    (hit),
            .wr_data   (wr_data),
            .freeze_lf (freeze_lf),
            .core_q    (core_q[i]),
            .busy      (busy_vec[i]),
            .lf_q      (lf_regs[i*DW +: DW])
        );

        assign core_flat[i*DW +: DW] = core_q[i];
    end

    lfreg_pub_xfer #(.DW(DW)) u_pub (
        .clk_core (clk_core),
        .clk_lf   (clk_lf),
        .rst_n    (rst_n),
        .lf_val   (lf_stat_in),
        .core_val (pub_val)
    );

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_addr == AW'(k)) rd_data = core_q[k];
        end
        if (rd_addr == AW'(N))     rd_data[N-1:0] = busy_vec;
        if (rd_addr == AW'(N + 1)) rd_data = pub_val;
    end
endmodule

// File: rtl/lfreg_sync_bank_chk.sv
module lfreg_sync_bank_chk #(
    parameter int N  = 4,
    parameter int DW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic            clk_core,
    input logic            clk_lf,
    input logic            rst_n,
    input logic            wr_en,
    input logic [IW-1:0]   wr_idx,
    input logic [N-1:0]    busy_vec,
    input logic [N*DW-1:0] core_flat,
    input logic [N*DW-1:0] lf_flat,
    input logic            freeze_lf
);
    for (genvar i = 0; i < N; i++) begin : g_chk
        // R2: an accepted write raises its own busy bit
        a_r2_busy_set: assert property (@(posedge clk_core) disable iff (!rst_n)
            (wr_en && wr_idx == IW'(i) && !busy_vec[i]) |=> busy_vec[i]);

        // R6: a write while busy leaves the holding copy alone
        a_r6_busy_write_ignored: assert property (@(posedge clk_core) disable iff (!rst_n)
            (wr_en && wr_idx == IW'(i) && busy_vec[i]) |=> $stable(core_flat[i*DW +: DW]));

        // R5: busy drops only once the shadow matches the holding copy
        a_r5_clear_after_update: assert property (@(posedge clk_core) disable iff (!rst_n)
            $fell(busy_vec[i]) |-> (lf_flat[i*DW +: DW] == core_flat[i*DW +: DW]));
    end

    // R8: no shadow moves on an edge where freeze was seen
    a_r8_freeze_hold: assert property (@(posedge clk_lf) disable iff (!rst_n)
        $past(freeze_lf) |-> $stable(lf_flat));
endmodule

bind lfreg_sync_bank lfreg_sync_bank_chk #(.N(N), .DW(DW)) u_chk (
    .clk_core  (clk_core),
    .clk_lf    (clk_lf),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .busy_vec  (busy_vec),
    .core_flat (core_flat),
    .lf_flat   (lf_regs),
    .freeze_lf (freeze_lf)
);

// File: tb/lfreg_sync_bank_test.sv
module lfreg_sync_bank_test;
    localparam int N  = 4;
    localparam int DW = 16;
    localparam int IW = 2;
    localparam int AW = 3;

    logic            clk_core = 1'b0;
    logic            clk_lf   = 1'b0;
    logic            rst_n    = 1'b0;
    logic            wr_en    = 1'b0;
    logic [IW-1:0]   wr_idx   = '0;
    logic [DW-1:0]   wr_data  = '0;
    logic [AW-1:0]   rd_addr  = '0;
    logic [DW-1:0]   rd_data;
    logic            freeze   = 1'b0;
    logic [DW-1:0]   lf_stat_in = '0;
    logic [N*DW-1:0] lf_regs;

    int checks = 0;
    int fails  = 0;

    lfreg_sync_bank #(.N(N), .DW(DW)) uut (
        .clk_core   (clk_core),
        .clk_lf     (clk_lf),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .freeze     (freeze),
        .lf_stat_in (lf_stat_in),
        .lf_regs    (lf_regs)
    );

    always #10 clk_core = ~clk_core;
    initial begin
        #5;
        forever #100 clk_lf = ~clk_lf;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input int idx, input logic [DW-1:0] d);
        @(negedge clk_core);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
        @(negedge clk_core);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] v);
        rd_addr = AW'(a);
        #1;
        v = rd_data;
    endtask

    function automatic logic [DW-1:0] shadow(input int idx);
        return lf_regs[idx*DW +: DW];
    endfunction

    task automatic t_reset;
        logic [DW-1:0] v;
        for (int a = 0; a < N + 2; a++) begin
            rd(a, v);
            chk("R1 readback zero", 32'(v), 32'h0);
        end
        chk("R1 shadows zero", 32'(lf_regs[31:0]), 32'h0);
        chk("R1 shadows zero hi", 32'(lf_regs[63:32]), 32'h0);
    endtask

    task automatic t_single;
        logic [DW-1:0] v;
        do_write(1, 16'hA55A);
        rd(N, v);
        chk("R2 busy bit set", 32'(v), 32'h2);
        rd(1, v);
        chk("R3 core copy readback", 32'(v), 32'hA55A);
        repeat (2) @(posedge clk_lf);
        #1;
        chk("R4 shadow old after 2 slow edges", 32'(shadow(1)), 32'h0);
        @(posedge clk_lf);
        #1;
        chk("R4 shadow new after 3rd slow edge", 32'(shadow(1)), 32'hA55A);
        rd(N, v);
        chk("R5 busy still set at 3rd slow edge", 32'(v), 32'h2);
        repeat (4) @(posedge clk_core);
        #1;
        rd(N, v);
        chk("R5 busy cleared", 32'(v), 32'h0);
    endtask

    task automatic t_double_write;
        logic [DW-1:0] v;
        do_write(2, 16'h1111);
        do_write(2, 16'h2222);
        rd(2, v);
        chk("R6 second write ignored in copy", 32'(v), 32'h1111);
        repeat (8) @(posedge clk_lf);
        #1;
        chk("R6 shadow holds first value", 32'(shadow(2)), 32'h1111);
        rd(N, v);
        chk("R6 busy clear after transfer", 32'(v), 32'h0);
    endtask

    task automatic t_parallel;
        logic [DW-1:0] v;
        @(negedge clk_core);
        wr_en = 1'b1; wr_idx = 2'd0; wr_data = 16'h0C0C;
        @(negedge clk_core);
        wr_idx = 2'd3; wr_data = 16'h3E3E;
        @(negedge clk_core);
        wr_en = 1'b0;
        rd(N, v);
        chk("R7 two busy bits", 32'(v), 32'h9);
        repeat (8) @(posedge clk_lf);
        #1;
        chk("R7 shadow 0", 32'(shadow(0)), 32'h0C0C);
        chk("R7 shadow 3", 32'(shadow(3)), 32'h3E3E);
        rd(N, v);
        chk("R7 busy clear", 32'(v), 32'h0);
    endtask

    task automatic t_freeze;
        logic [DW-1:0] v;
        @(negedge clk_core);
        freeze = 1'b1;
        repeat (4) @(posedge clk_lf);
        do_write(0, 16'h7001);
        do_write(1, 16'h7002);
        repeat (10) @(posedge clk_lf);
        #1;
        chk("R8 shadow 0 held", 32'(shadow(0)), 32'h0C0C);
        chk("R8 shadow 1 held", 32'(shadow(1)), 32'hA55A);
        rd(N, v);
        chk("R8 busy held", 32'(v), 32'h3);
        @(negedge clk_core);
        freeze = 1'b0;
        repeat (6) @(posedge clk_lf);
        #1;
        chk("R8 shadow 0 released", 32'(shadow(0)), 32'h7001);
        chk("R8 shadow 1 released", 32'(shadow(1)), 32'h7002);
        rd(N, v);
        chk("R8 busy clear after release", 32'(v), 32'h0);
    endtask

    task automatic t_publish;
        logic [DW-1:0] v;
        @(negedge clk_core);
        lf_stat_in = 16'hBEEF;
        repeat (12) @(posedge clk_lf);
        @(negedge clk_core);
        rd(N + 1, v);
        chk("R9 published value", 32'(v), 32'hBEEF);
        lf_stat_in = 16'h1234;
        repeat (12) @(posedge clk_lf);
        @(negedge clk_core);
        rd(N + 1, v);
        chk("R9 published value follows", 32'(v), 32'h1234);
    endtask

    task automatic t_unmapped;
        logic [DW-1:0] v;
        for (int a = N + 2; a < (1 << AW); a++) begin
            rd(a, v);
            chk("R10 unmapped reads zero", 32'(v), 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_core);
        t_reset;
        rst_n = 1'b1;
        repeat (4) @(posedge clk_lf);
        @(negedge clk_core);
        t_reset;
        t_single;
        t_double_write;
        t_parallel;
        t_freeze;
        t_publish;
        t_unmapped;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule